// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Tick

This block is a timer peripheral built around a free-running counter that advances on every clock. By default the counter is 40 bits wide. Software reads it as a 32-bit low word and an 8-bit high word. Reading the low word on its own gives a valid count that wraps modulo 2^32, so the low word can serve directly as a free-running time source. An alarm comparator watches the whole counter. A separate down-counter produces a periodic tick at a rate set by a reload value.

A small register bus writes the control, alarm and reload registers on the clock edge and reads every register combinationally. Three sticky event flags are shown in the top bits of a status register and are also driven out as interrupt lines: counter wrap, alarm hit and periodic tick. Software clears a flag by writing 1 to its status bit. The control register has three freeze bits, one each for the low part of the counter, the high part and the periodic timer. It also has a clear bit that holds the counter at zero. Writing zero to the control register returns the timer to its idle state.

Top module: `rtc_alarm_timer`

## Requirements
- R1: The counter advances by one on every clock edge. Its low part (LO_W bits, 32 by default, read at word address 1) wraps modulo 2^LO_W and carries into the high part (HI_W bits, 8 by default, read at word address 2).
- R2: The control register (word address 0) holds three freeze bits: bit 0 freezes the high part, bit 1 freezes the low part and bit 2 freezes the periodic down-counter. A frozen part keeps its value. A carry out of the low part is lost while the high part is frozen.
- R3: While control bit 3 (clear) is set, the counter is forced to zero and does not advance. Once a write to the control register removes the bit, counting starts again from zero.
- R4: A write of all zeros to the control register has the following effects on that same edge: the counter goes to zero, all three flags clear, and the periodic timer stops. The alarm and reload registers keep their values.
- R5: Control bit 4 enables the periodic timer, and the reload value is held at word address 5. The enabling write is followed by one load cycle, so the first tick flag appears reload+2 edges after that write. After that, a tick comes every reload+1 clocks. A reload value of zero gives a tick on every clock.
- R6: The alarm flag sets on the edge at which the counter moves to a value equal to {alarm high (word address 4), alarm low (word address 3)}. It does not set again while the counter stays there, and after a clear it does not set again until the counter returns to that value.
- R7: The wrap flag sets on the edge at which the full counter goes from all ones to zero.
- R8: The alarm high register stores only the bits that are set in the ALM_HI_MASK parameter. All other bits read as zero.
- R9: The flags sit in the status register (word address 6): bit 31 is wrap, bit 30 is alarm and bit 29 is tick. Each flag stays set until 1 is written to its bit. If a new event arrives on the same edge as the clear, the flag stays set. The outputs irq_roll, irq_alarm and irq_tick follow these bits.
- R10: Writes to the counter addresses (1 and 2) are ignored. The count carries on without disturbance.
- R11: After reset, the control, alarm, reload and status registers all read zero. Reads are combinational in the same cycle, and addresses with nothing mapped read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_roll | output | 1 | Counter wrap flag |
| irq_alarm | output | 1 | Alarm hit flag |
| irq_tick | output | 1 | Periodic tick flag |

## Verification
A write becomes effective on the edge that samples it. A zero write therefore leaves the counter at 0 on that edge and at k after k more edges. The alarm flag is visible on the very edge at which the counter takes the target value. The first tick arrives reload+2 edges after the enabling write and later ticks every reload+1 edges. The bench counts rising edges and tags every write with the number of the edge that applied it. Each snapshot is taken at the falling edge that follows an exact computed edge number. Each timed result is checked both one edge before it is due and on the edge it is due, so a result that arrives early or late is caught.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
   localparam int unsigned BUS_W = 32;

   typedef enum logic [2:0] {
      REG_CTRL   = 3'd0,
      REG_CNT_LO = 3'd1,
      REG_CNT_HI = 3'd2,
      REG_ALM_LO = 3'd3,
      REG_ALM_HI = 3'd4,
      REG_RELOAD = 3'd5,
      REG_STATUS = 3'd6
   } reg_addr_e;

   // control bit positions
   localparam int CB_FRZ_HI  = 0;
   localparam int CB_FRZ_LO  = 1;
   localparam int CB_FRZ_PER = 2;
   localparam int CB_CLR     = 3;
   localparam int CB_PER_EN  = 4;

   typedef struct packed {
      logic per_en;
      logic clr;
      logic frz_per;
      logic frz_lo;
      logic frz_hi;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // status flag positions: wrap, alarm, tick
   localparam int SB_ROLL  = 31;
   localparam int SB_ALARM = 30;
   localparam int SB_TICK  = 29;
   localparam int N_FLAGS  = 3;
endpackage

// File: rtl/rtc_counter.sv
`timescale 1ns/1ps
module rtc_counter #(
   parameter int LO_W = 32,
   parameter int HI_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_clr,
   input  logic                 hold_zero,
   input  logic                 frz_lo,
   input  logic                 frz_hi,
   output logic [LO_W-1:0]      lo_q,
   output logic [HI_W-1:0]      hi_q,
   output logic [LO_W+HI_W-1:0] cnt_nxt,
   output logic                 wrap_evt
);
   localparam int CNT_W = LO_W + HI_W;

   generate
      if (LO_W < 1 || LO_W > 32) begin : g_bad_lo
         $error("rtc_counter: LO_W must be 1..32");
      end
      if (HI_W < 1 || HI_W > 32) begin : g_bad_hi
         $error("rtc_counter: HI_W must be 1..32");
      end
   endgenerate

   logic            zero_now;
   logic            lo_carry;
   logic            hi_step;
   logic [LO_W-1:0] lo_nxt;
   logic [HI_W-1:0] hi_nxt;

   always_comb begin
      zero_now = soft_clr | hold_zero;
      lo_carry = !frz_lo && (&lo_q);
      hi_step  = lo_carry && !frz_hi;
      lo_nxt   = frz_lo  ? lo_q : lo_q + 1'b1;
      hi_nxt   = hi_step ? hi_q + 1'b1 : hi_q;
      if (zero_now) begin
         lo_nxt = '0;
         hi_nxt = '0;
      end
      wrap_evt = hi_step && (&hi_q) && !zero_now;
      cnt_nxt  = CNT_W'({hi_nxt, lo_nxt});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_nxt;
         hi_q <= hi_nxt;
      end
   end

   AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!frz_lo && !hold_zero && !soft_clr) |=> (lo_q == $past(lo_q) + 1'b1)); // R1
   AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_lo && !hold_zero && !soft_clr) |=> $stable(lo_q)); // R2
   AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_hi && !hold_zero && !soft_clr) |=> $stable(hi_q)); // R2
   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hold_zero |=> (lo_q == '0 && hi_q == '0)); // R3
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> (lo_q == '0 && hi_q == '0)); // R7
endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
module rtc_alarm #(
   parameter int CNT_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] target,
   output logic             hit
);
   // fire only when the counter moves onto the target value
   always_comb hit = (cnt_nxt == target) && (cnt_nxt != cnt_q);

   AST_ALARM_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cnt_q == $past(target))); // R6
   AST_ALARM_NOT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !$stable(cnt_q)); // R6
endmodule

// File: rtl/rtc_periodic.sv
`timescale 1ns/1ps
module rtc_periodic #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             en,
   input  logic             frz,
   input  logic [PER_W-1:0] reload,
   output logic             tick
);
   generate
      if (PER_W < 1 || PER_W > 32) begin : g_bad_per
         $error("rtc_periodic: PER_W must be 1..32");
      end
   endgenerate

   logic [PER_W-1:0] cnt_q;
   logic             en_q;
   logic             start;

   always_comb begin
      start = en && !en_q;
      tick  = en && en_q && !frz && (cnt_q == '0) && !soft_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else if (soft_clr) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         en_q <= en;
         if (start)
            cnt_q <= reload;
         else if (en && !frz)
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
      end
   end

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !soft_clr) |=> (cnt_q == $past(reload))); // R5
   AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == $past(reload))); // R5
   AST_PER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && en_q && frz && !soft_clr) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/rtc_flags.sv
`timescale 1ns/1ps
module rtc_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag_q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_q[i] <= 1'b0;
            else if (soft_clr)
               flag_q[i] <= 1'b0;
            else
               flag_q[i] <= set[i] | (flag_q[i] & ~clr[i]);
         end

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !soft_clr) |=> flag_q[i]); // R9
         AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flag_q[i]); // R9
         AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr[i] && !soft_clr) |=> flag_q[i]); // R9
      end
   endgenerate
endmodule

// File: rtl/rtc_alarm_timer.sv
`timescale 1ns/1ps
module rtc_alarm_timer
   import rtc_pkg::*;
#(
   parameter int              LO_W        = 32,
   parameter int              HI_W        = 8,
   parameter int              PER_W       = 16,
   parameter logic [HI_W-1:0] ALM_HI_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq_roll,
   output logic             irq_alarm,
   output logic             irq_tick
);
   localparam int CNT_W = LO_W + HI_W;

   generate
      if (LO_W > BUS_W || HI_W > BUS_W || PER_W > BUS_W) begin : g_bad_width
         $error("rtc_alarm_timer: field wider than the bus");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [LO_W-1:0]    alm_lo_q;
   logic [HI_W-1:0]    alm_hi_q;
   logic [PER_W-1:0]   reload_q;
   logic [LO_W-1:0]    lo_q;
   logic [HI_W-1:0]    hi_q;
   logic [CNT_W-1:0]   cnt_nxt;
   logic               wrap_evt;
   logic               alarm_hit;
   logic               tick;
   logic               soft_clr;
   logic [N_FLAGS-1:0] flag_set;
   logic [N_FLAGS-1:0] flag_clr;
   logic [N_FLAGS-1:0] flag_q;

   always_comb begin
      soft_clr = bus_wr && (bus_addr == REG_CTRL) && (bus_wdata == '0);
      flag_clr = (bus_wr && bus_addr == REG_STATUS) ?
                 bus_wdata[SB_ROLL:SB_TICK] : '0;
      flag_set = {wrap_evt, alarm_hit, tick};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         alm_lo_q <= '0;
         alm_hi_q <= '0;
         reload_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            REG_CTRL:   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            REG_ALM_LO: alm_lo_q <= bus_wdata[LO_W-1:0];
            REG_ALM_HI: alm_hi_q <= bus_wdata[HI_W-1:0] & ALM_HI_MASK;
            REG_RELOAD: reload_q <= bus_wdata[PER_W-1:0];
            default: ;
         endcase
      end
   end

   rtc_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .hold_zero (ctrl_q.clr),
      .frz_lo    (ctrl_q.frz_lo),
      .frz_hi    (ctrl_q.frz_hi),
      .lo_q      (lo_q),
      .hi_q      (hi_q),
      .cnt_nxt   (cnt_nxt),
      .wrap_evt  (wrap_evt)
   );

   rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_q   ({hi_q, lo_q}),
      .cnt_nxt (cnt_nxt),
      .target  ({alm_hi_q, alm_lo_q}),
      .hit     (alarm_hit)
   );

   rtc_periodic #(.PER_W(PER_W)) u_periodic (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .en       (ctrl_q.per_en),
      .frz      (ctrl_q.frz_per),
      .reload   (reload_q),
      .tick     (tick)
   );

   rtc_flags #(.N(N_FLAGS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .set      (flag_set),
      .clr      (flag_clr),
      .flag_q   (flag_q)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL:   bus_rdata = BUS_W'(ctrl_q);
         REG_CNT_LO: bus_rdata = BUS_W'(lo_q);
         REG_CNT_HI: bus_rdata = BUS_W'(hi_q);
         REG_ALM_LO: bus_rdata = BUS_W'(alm_lo_q);
         REG_ALM_HI: bus_rdata = BUS_W'(alm_hi_q);
         REG_RELOAD: bus_rdata = BUS_W'(reload_q);
         REG_STATUS: bus_rdata[SB_ROLL:SB_TICK] = flag_q;
         default: ;
      endcase
      irq_roll  = flag_q[2];
      irq_alarm = flag_q[1];
      irq_tick  = flag_q[0];
   end

   AST_ZERO_WRITE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (flag_q == '0 && lo_q == '0 && hi_q == '0 && ctrl_q == '0)); // R4
   AST_ALM_HI_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_ALM_HI) |=>
      (alm_hi_q == ($past(bus_wdata[HI_W-1:0]) & ALM_HI_MASK))); // R8
endmodule

// File: tb/rtc_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_timer_tb_top;
   import rtc_pkg::*;

   localparam int              LO_W = 10;
   localparam int              HI_W = 4;
   localparam int              PER_W = 8;
   localparam logic [HI_W-1:0] MASK = 4'h7;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr;
   logic [2:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        irq_roll, irq_alarm, irq_tick;

   always #2 clk = ~clk;

   rtc_alarm_timer #(.LO_W(LO_W), .HI_W(HI_W), .PER_W(PER_W), .ALM_HI_MASK(MASK)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_roll(irq_roll), .irq_alarm(irq_alarm), .irq_tick(irq_tick)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] s_ctrl, s_lo, s_hi, s_st;
   logic [2:0]  s_irq;

   localparam logic [31:0] C_FRZ_HI  = 32'(1) << CB_FRZ_HI;
   localparam logic [31:0] C_FRZ_LO  = 32'(1) << CB_FRZ_LO;
   localparam logic [31:0] C_FRZ_PER = 32'(1) << CB_FRZ_PER;
   localparam logic [31:0] C_CLR     = 32'(1) << CB_CLR;
   localparam logic [31:0] C_PER_EN  = 32'(1) << CB_PER_EN;

   function automatic logic [31:0] exp_lo(input int k);
      return 32'(k % (1 << LO_W));
   endfunction
   function automatic logic [31:0] exp_hi(input int k);
      return 32'((k >> LO_W) % (1 << HI_W));
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      e = cyc;
   endtask

   task automatic rd_now(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic snap_at(input int n);
      @(negedge clk);
      while (cyc < n) @(negedge clk);
      if (cyc != n) chk("BENCH", "snapshot edge", 32'(cyc), 32'(n));
      bus_addr = REG_CTRL;   #0.3 s_ctrl = bus_rdata;
      bus_addr = REG_CNT_LO; #0.3 s_lo   = bus_rdata;
      bus_addr = REG_CNT_HI; #0.3 s_hi   = bus_rdata;
      bus_addr = REG_STATUS; #0.3 s_st   = bus_rdata;
      s_irq = {irq_roll, irq_alarm, irq_tick};
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      int e, f, g, c, w, a_val, r_val, d;
      logic [31:0] v;
      void'($urandom(32'd4242));
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      snap_at(cyc + 1);
      chk("R11", "ctrl after reset", s_ctrl, 32'h0);
      chk("R11", "status after reset", s_st, 32'h0);
      chk("R11", "irq after reset", 32'(s_irq), 32'h0);
      rd_now(REG_ALM_LO, v); chk("R11", "alarm lo after reset", v, 32'h0);
      rd_now(REG_ALM_HI, v); chk("R11", "alarm hi after reset", v, 32'h0);
      rd_now(REG_RELOAD, v); chk("R11", "reload after reset", v, 32'h0);
      rd_now(3'd7, v);       chk("R11", "unmapped address", v, 32'h0);

      // R1 counting and carry into the high part
      wr(REG_CTRL, 32'h0, e);
      snap_at(e + 37);
      chk("R1", "low after 37", s_lo, 32'd37);
      chk("R1", "high after 37", s_hi, 32'd0);
      snap_at(e + (1 << LO_W));
      chk("R1", "low after wrap", s_lo, 32'd0);
      chk("R1", "high after carry", s_hi, 32'd1);

      // R10 counter registers ignore writes
      wr(REG_CNT_LO, 32'h155, w);
      wr(REG_CNT_HI, 32'h5, w);
      snap_at(w + 2);
      chk("R10", "low after write", s_lo, exp_lo(w + 2 - e));
      chk("R10", "high after write", s_hi, exp_hi(w + 2 - e));

      // R2 frozen high part drops the carry
      wr(REG_CTRL, 32'h0, e);
      wr(REG_CTRL, C_FRZ_HI, f);
      snap_at(e + (1 << LO_W) + 6);
      chk("R2", "low runs with high frozen", s_lo, 32'd6);
      chk("R2", "high frozen", s_hi, 32'd0);

      // R2 frozen low part
      wr(REG_CTRL, 32'h0, e);
      d = 5 + int'($urandom % 200);
      repeat (d) @(posedge clk);
      wr(REG_CTRL, C_FRZ_LO, f);
      snap_at(f + 25);
      chk("R2", "low frozen", s_lo, exp_lo(f - e));

      // R3 clear holds zero, release restarts from zero
      wr(REG_CTRL, C_CLR, f);
      snap_at(f + 6);
      chk("R3", "low held at zero", s_lo, 32'd0);
      chk("R3", "high held at zero", s_hi, 32'd0);
      wr(REG_CTRL, C_FRZ_PER, g);
      snap_at(g + 9);
      chk("R3", "count after release", s_lo, 32'd9);

      // R6 alarm, two random targets
      for (int i = 0; i < 2; i++) begin
         a_val = 50 + int'($urandom % 850);
         wr(REG_ALM_HI, 32'h0, w);
         wr(REG_ALM_LO, 32'(a_val), w);
         wr(REG_CTRL, 32'h0, e);
         snap_at(e + a_val - 1);
         chk("R6", "alarm not yet", 32'(s_st[SB_ALARM]), 32'd0);
         snap_at(e + a_val);
         chk("R6", "alarm set on match", 32'(s_st[SB_ALARM]), 32'd1);
         chk("R9", "irq_alarm mirrors flag", 32'(s_irq[1]), 32'd1);
         chk("R6", "count at alarm", s_lo, 32'(a_val));
         wr(REG_STATUS, 32'(1) << SB_ALARM, c);
         snap_at(c + 1);
         chk("R9", "alarm cleared by write 1", 32'(s_st[SB_ALARM]), 32'd0);
         snap_at(c + 40);
         chk("R6", "alarm not raised again", 32'(s_st[SB_ALARM]), 32'd0);
      end

      // R8 alarm high mask
      wr(REG_ALM_HI, 32'hFF, w);
      rd_now(REG_ALM_HI, v);
      chk("R8", "alarm hi masked", v, 32'(MASK));
      wr(REG_ALM_HI, 32'h0, w);

      // R5 periodic tick, random reload values
      for (int i = 0; i < 3; i++) begin
         r_val = 3 + int'($urandom % 28);
         wr(REG_RELOAD, 32'(r_val), w);
         wr(REG_CTRL, 32'h0, w);
         wr(REG_CTRL, C_PER_EN, e);
         snap_at(e + r_val + 1);
         chk("R5", "no early tick", 32'(s_st[SB_TICK]), 32'd0);
         snap_at(e + r_val + 2);
         chk("R5", "first tick", 32'(s_st[SB_TICK]), 32'd1);
         chk("R9", "irq_tick mirrors flag", 32'(s_irq[0]), 32'd1);
         wr(REG_STATUS, 32'(1) << SB_TICK, c);
         snap_at(e + 2 * r_val + 2);
         chk("R5", "no tick inside period", 32'(s_st[SB_TICK]), 32'd0);
         snap_at(e + 2 * r_val + 3);
         chk("R5", "second tick after reload+1", 32'(s_st[SB_TICK]), 32'd1);
      end

      // R2 periodic freeze stops ticks
      wr(REG_CTRL, C_PER_EN | C_FRZ_PER, f);
      wr(REG_STATUS, 32'(1) << SB_TICK, c);
      snap_at(c + 3 * r_val + 5);
      chk("R2", "no tick while frozen", 32'(s_st[SB_TICK]), 32'd0);

      // R5 / R9 reload zero ticks every clock; set beats clear
      wr(REG_RELOAD, 32'h0, w);
      wr(REG_CTRL, 32'h0, w);
      wr(REG_CTRL, C_PER_EN, e);
      snap_at(e + 3);
      chk("R5", "reload zero ticking", 32'(s_st[SB_TICK]), 32'd1);
      wr(REG_STATUS, 32'(1) << SB_TICK, c);
      snap_at(c);
      chk("R9", "set wins over clear", 32'(s_st[SB_TICK]), 32'd1);

      // R4 zero write resets the module
      wr(REG_ALM_LO, 32'd1000, w);
      wr(REG_CTRL, 32'h0, e);
      snap_at(e);
      chk("R4", "ctrl zero", s_ctrl, 32'h0);
      chk("R4", "flags cleared", s_st, 32'h0);
      chk("R4", "counter zero", s_lo, 32'h0);
      snap_at(e + 30);
      chk("R4", "periodic stopped", s_st, 32'h0);
      chk("R4", "counter restarted", s_lo, 32'd30);
      rd_now(REG_ALM_LO, v);
      chk("R4", "alarm lo kept", v, 32'd1000);

      // R7 full counter wrap
      wr(REG_CTRL, 32'h0, e);
      snap_at(e + (1 << (LO_W + HI_W)) - 1);
      chk("R7", "no wrap flag yet", 32'(s_st[SB_ROLL]), 32'd0);
      chk("R1", "low all ones", s_lo, exp_lo((1 << (LO_W + HI_W)) - 1));
      chk("R1", "high all ones", s_hi, exp_hi((1 << (LO_W + HI_W)) - 1));
      snap_at(e + (1 << (LO_W + HI_W)));
      chk("R7", "wrap flag set", 32'(s_st[SB_ROLL]), 32'd1);
      chk("R9", "irq_roll mirrors flag", 32'(s_irq[2]), 32'd1);
      chk("R7", "low wrapped", s_lo, 32'd0);
      chk("R7", "high wrapped", s_hi, 32'd0);

      report();
   end
endmodule